// File: doc/BRIEF.md
# Packed 9-bit Symbol Error Corrector

This block repairs a 512-byte sector held in its own single-port buffer, using the error records that a separate syndrome decoder produces. The sector is treated as a run of 9-bit symbols packed little-endian, so most symbols straddle two bytes. Each record names one symbol, counted from one, and carries a 9-bit XOR mask. For every record that lands inside the sector, the unit reads the two bytes under the symbol, flips the masked bits and writes both bytes back.

Before a run, the sector bytes and the nine parity bytes are streamed in through a load port. While they stream, the block checks whether every byte is 0xFF. A sector that was never programmed gives that pattern, and its parity must not be "corrected". A run is started with an error count and an uncorrectable flag. The unit fetches records by index from the caller and finishes with a one-cycle done pulse. Alongside the pulse it reports how many records it applied, whether the sector was flagged uncorrectable, and whether it was found erased. After the run, the repaired bytes can be read back through a read port.

Top module: `sec_fix_top`

## Requirements
- R1: In a record, bits 24:16 carry the symbol location plus one and bits 8:0 carry the XOR mask. All other record bits have no effect.
- R2: A record with location L (symbol i = L-1) XORs the mask, shifted left by i&7, into the 16-bit little-endian pair starting at byte i+(i>>3). The lower byte sits at that address.
- R3: A record is skipped and not counted when L is 0, or when its starting byte i+(i>>3) is 512 or more (i greater than 455).
- R4: When the starting byte is 511, only that byte is changed. The write to the nonexistent byte 512 is suppressed, and the record still counts as applied.
- R5: A run processes records 0 to count-1 (count is 3 bits, 0 to 7) in index order, presenting each index on rec_idx_o. A count of 0 ends the run with no change.
- R6: With the uncorrectable flag set on a non-erased sector, the buffer is unchanged, fail_o is 1 and fixed_o is 0.
- R7: If all 521 bytes loaded since the previous done are 0xFF, the run makes no change and reports erased_o=1, fail_o=0 and fixed_o=0, even with the uncorrectable flag set. A single byte that is not 0xFF makes erased_o 0.
- R8: done_o is a single-cycle pulse at the end of every run. fixed_o equals the number of records applied and holds until the next start.
- R9: Load writes and start requests that arrive while busy_o is 1 are ignored.
- R10: While idle, rd_data_o shows the buffer byte at rd_addr_i one cycle after the address is presented. A load with ld_par_i=0 writes ld_data_i to ld_addr_i. A load with ld_par_i=1 only feeds erased detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | Load strobe for one byte |
| ld_par_i | input | 1 | 1: parity byte (detection only), 0: sector byte |
| ld_addr_i | input | 9 | Sector byte address for a load |
| ld_data_i | input | 8 | Load data |
| rd_addr_i | input | 9 | Readback address |
| rd_data_o | output | 8 | Readback data, one cycle after the address |
| start_i | input | 1 | Begin a correction run |
| err_cnt_i | input | 3 | Number of records for the run |
| uncor_i | input | 1 | Decoder flagged the sector uncorrectable |
| rec_idx_o | output | 3 | Index of the record being requested |
| rec_i | input | 32 | Record for the requested index |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | End-of-run pulse |
| fail_o | output | 1 | Uncorrectable result of the last run |
| erased_o | output | 1 | Last run found an erased sector |
| fixed_o | output | 3 | Records applied in the last run |

## Verification
The bench sweeps every location from 0 to 511, seven records per run, against a byte-array model. This exposes a wrong byte or bit offset, a lost high byte on a straddling symbol, a fault at the 455/456 boundary, and an off-by-one on the 1-based location field. An engine that overruns the buffer at byte 511, or drops the low byte there, corrupts the final readback. Zero counts, repeated records that cancel each other, uncorrectable runs and loads or starts issued mid-run are each checked for unwanted buffer changes. An all-0xFF sector is run with the uncorrectable flag set, and a copy with one parity byte differing is run as well, to confirm that the erased bypass is taken only when every byte qualifies.

// File: rtl/sec_fix_pkg.sv
package sec_fix_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_NEXT, ST_RD0, ST_RD1, ST_WR0, ST_WR1, ST_FIN
  } fix_state_e;
endpackage

// File: rtl/sec_fix_ram.sv
module sec_fix_ram #(
  parameter int BYTES = 512,
  parameter int AW    = $clog2(BYTES)
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    q_o
);
  logic [7:0] mem [BYTES];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem[addr_i] <= wdata_i;
      else      q_o <= mem[addr_i];
    end
  end
endmodule

// File: rtl/sec_fix_erased.sv
module sec_fix_erased #(
  parameter int BYTES     = 512,
  parameter int PAR_BYTES = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       clear_i,
  output logic       erased_o
);
  localparam int TOTAL = BYTES + PAR_BYTES;
  localparam int SW    = $clog2(TOTAL + 1);
  localparam logic [SW-1:0] TOTAL_C = SW'(TOTAL);

  logic [SW-1:0] seen_q;
  logic          all_ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q   <= '0;
      all_ff_q <= 1'b1;
    end else if (clear_i) begin
      seen_q   <= '0;
      all_ff_q <= 1'b1;
    end else if (byte_valid_i) begin
      if (seen_q != TOTAL_C) seen_q <= seen_q + 1'b1;
      if (byte_i != 8'hFF) all_ff_q <= 1'b0;
    end
  end

  assign erased_o = all_ff_q && (seen_q == TOTAL_C);
endmodule

// File: rtl/sec_fix_decode.sv
module sec_fix_decode #(
  parameter int REC_W   = 32,
  parameter int SYM_W   = 9,
  parameter int LOC_W   = 9,
  parameter int LOC_LSB = 16,
  parameter int NUM_SYM = 512,
  parameter int BYTES   = 512,
  parameter int BA_W    = $clog2(BYTES) + 2
) (
  input  logic [REC_W-1:0] rec_i,
  output logic             valid_o,
  output logic [BA_W-1:0]  base_o,
  output logic [2:0]       off_o,
  output logic             hi_ok_o,
  output logic [SYM_W-1:0] mask_o
);
  localparam logic [BA_W-1:0] NSYM_C  = BA_W'(NUM_SYM);
  localparam logic [BA_W-1:0] BYTES_C = BA_W'(BYTES);

  logic [LOC_W-1:0] loc;
  logic [BA_W-1:0]  idx;

  always_comb begin
    loc     = rec_i[LOC_LSB +: LOC_W];
    idx     = BA_W'(loc) - 1'b1;
    base_o  = idx + (idx >> 3);
    off_o   = idx[2:0];
    mask_o  = rec_i[SYM_W-1:0];
    valid_o = (loc != '0) && (idx < NSYM_C) && (base_o < BYTES_C);
    hi_ok_o = (base_o + 1'b1) < BYTES_C;
  end
endmodule

// File: rtl/sec_fix_engine.sv
module sec_fix_engine
  import sec_fix_pkg::*;
#(
  parameter int BYTES = 512,
  parameter int AW    = $clog2(BYTES),
  parameter int BA_W  = AW + 2,
  parameter int SYM_W = 9,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             uncor_i,
  input  logic             erased_i,
  input  logic             rec_valid_i,
  input  logic [BA_W-1:0]  rec_base_i,
  input  logic [2:0]       rec_off_i,
  input  logic             rec_hi_ok_i,
  input  logic [SYM_W-1:0] rec_mask_i,
  input  logic [7:0]       ram_q_i,
  output logic             ram_en_o,
  output logic             ram_we_o,
  output logic [AW-1:0]    ram_addr_o,
  output logic [7:0]       ram_wdata_o,
  output logic [CNT_W-1:0] rec_idx_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic             erased_o,
  output logic [CNT_W-1:0] fixed_o
);
  fix_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, idx_q, fixed_q;
  logic             uncor_q, erased_q, hi_ok_q;
  logic [BA_W-1:0]  base_q;
  logic [2:0]       off_q;
  logic [SYM_W-1:0] mask_q;
  logic [7:0]       lo_q, hi_new_q;
  logic [15:0]      flip, pair;
  logic [AW-1:0]    lo_addr, hi_addr;

  assign lo_addr = base_q[AW-1:0];
  assign hi_addr = lo_addr + 1'b1;
  assign flip    = 16'(mask_q) << off_q;
  assign pair    = {ram_q_i, lo_q} ^ flip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      fixed_q  <= '0;
      uncor_q  <= 1'b0;
      erased_q <= 1'b0;
      hi_ok_q  <= 1'b0;
      base_q   <= '0;
      off_q    <= '0;
      mask_q   <= '0;
      lo_q     <= '0;
      hi_new_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cnt_q    <= cnt_i;
          uncor_q  <= uncor_i;
          erased_q <= erased_i;
          idx_q    <= '0;
          fixed_q  <= '0;
          state_q  <= ST_NEXT;
        end
        ST_NEXT: begin
          // erased sector takes priority over the uncorrectable flag
          if (erased_q || uncor_q || idx_q == cnt_q) state_q <= ST_FIN;
          else if (rec_valid_i) begin
            base_q  <= rec_base_i;
            off_q   <= rec_off_i;
            mask_q  <= rec_mask_i;
            hi_ok_q <= rec_hi_ok_i;
            state_q <= ST_RD0;
          end else idx_q <= idx_q + 1'b1;
        end
        ST_RD0: state_q <= ST_RD1;
        ST_RD1: begin
          lo_q    <= ram_q_i;
          state_q <= ST_WR0;
        end
        ST_WR0: begin
          hi_new_q <= pair[15:8];
          state_q  <= ST_WR1;
        end
        ST_WR1: begin
          fixed_q <= fixed_q + 1'b1;
          idx_q   <= idx_q + 1'b1;
          state_q <= ST_NEXT;
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ram_en_o    = 1'b0;
    ram_we_o    = 1'b0;
    ram_addr_o  = lo_addr;
    ram_wdata_o = pair[7:0];
    unique case (state_q)
      ST_RD0: ram_en_o = 1'b1;
      ST_RD1: begin
        ram_en_o   = hi_ok_q;
        ram_addr_o = hi_addr;
      end
      ST_WR0: begin
        ram_en_o = 1'b1;
        ram_we_o = 1'b1;
      end
      ST_WR1: begin
        ram_en_o    = hi_ok_q;
        ram_we_o    = hi_ok_q;
        ram_addr_o  = hi_addr;
        ram_wdata_o = hi_new_q;
      end
      default: ;
    endcase
  end

  assign rec_idx_o = idx_q;
  assign busy_o    = state_q != ST_IDLE;
  assign done_o    = state_q == ST_FIN;
  assign fail_o    = uncor_q && !erased_q;
  assign erased_o  = erased_q;
  assign fixed_o   = fixed_q;
endmodule

// File: rtl/sec_fix_top.sv
module sec_fix_top #(
  parameter int BYTES     = 512,
  parameter int PAR_BYTES = 9,
  parameter int REC_W     = 32,
  parameter int SYM_W     = 9,
  parameter int LOC_W     = 9,
  parameter int LOC_LSB   = 16,
  parameter int NUM_SYM   = 512,
  parameter int CNT_W     = 3,
  localparam int AW       = $clog2(BYTES),
  localparam int BA_W     = AW + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_valid_i,
  input  logic             ld_par_i,
  input  logic [AW-1:0]    ld_addr_i,
  input  logic [7:0]       ld_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [7:0]       rd_data_o,
  input  logic             start_i,
  input  logic [CNT_W-1:0] err_cnt_i,
  input  logic             uncor_i,
  output logic [CNT_W-1:0] rec_idx_o,
  input  logic [REC_W-1:0] rec_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic             erased_o,
  output logic [CNT_W-1:0] fixed_o
);
  logic             ld_ok, det_erased;
  logic             rec_valid, rec_hi_ok;
  logic [BA_W-1:0]  rec_base;
  logic [2:0]       rec_off;
  logic [SYM_W-1:0] rec_mask;
  logic             e_en, e_we, ram_en, ram_we;
  logic [AW-1:0]    e_addr, ram_addr;
  logic [7:0]       e_wdata, ram_wdata, ram_q;

  assign ld_ok = ld_valid_i && !busy_o;

  sec_fix_erased #(.BYTES(BYTES), .PAR_BYTES(PAR_BYTES)) u_erased (
    .clk_i, .rst_ni,
    .byte_valid_i(ld_ok),
    .byte_i      (ld_data_i),
    .clear_i     (done_o),
    .erased_o    (det_erased)
  );

  sec_fix_decode #(
    .REC_W(REC_W), .SYM_W(SYM_W), .LOC_W(LOC_W), .LOC_LSB(LOC_LSB),
    .NUM_SYM(NUM_SYM), .BYTES(BYTES), .BA_W(BA_W)
  ) u_decode (
    .rec_i, .valid_o(rec_valid), .base_o(rec_base), .off_o(rec_off),
    .hi_ok_o(rec_hi_ok), .mask_o(rec_mask)
  );

  sec_fix_engine #(
    .BYTES(BYTES), .AW(AW), .BA_W(BA_W), .SYM_W(SYM_W), .CNT_W(CNT_W)
  ) u_engine (
    .clk_i, .rst_ni, .start_i,
    .cnt_i(err_cnt_i), .uncor_i, .erased_i(det_erased),
    .rec_valid_i(rec_valid), .rec_base_i(rec_base), .rec_off_i(rec_off),
    .rec_hi_ok_i(rec_hi_ok), .rec_mask_i(rec_mask), .ram_q_i(ram_q),
    .ram_en_o(e_en), .ram_we_o(e_we), .ram_addr_o(e_addr), .ram_wdata_o(e_wdata),
    .rec_idx_o, .busy_o, .done_o, .fail_o, .erased_o, .fixed_o
  );

  // the engine owns the single port while busy
  always_comb begin
    if (busy_o) begin
      ram_en = e_en; ram_we = e_we; ram_addr = e_addr; ram_wdata = e_wdata;
    end else if (ld_valid_i && !ld_par_i) begin
      ram_en = 1'b1; ram_we = 1'b1; ram_addr = ld_addr_i; ram_wdata = ld_data_i;
    end else begin
      ram_en = 1'b1; ram_we = 1'b0; ram_addr = rd_addr_i; ram_wdata = ld_data_i;
    end
  end

  sec_fix_ram #(.BYTES(BYTES), .AW(AW)) u_ram (
    .clk_i, .en_i(ram_en), .we_i(ram_we), .addr_i(ram_addr),
    .wdata_i(ram_wdata), .q_o(ram_q)
  );

  assign rd_data_o = ram_q;
endmodule

// File: rtl/sec_fix_chk.sv
module sec_fix_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             fail_o,
  input logic             erased_o,
  input logic [CNT_W-1:0] fixed_o
);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(fixed_o));
  // R6
  uncor_nofix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fail_o) |-> fixed_o == '0);
  // R7
  erased_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && erased_o) |-> (fixed_o == '0 && !fail_o));
  // R9
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));
  // R5
  start_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
endmodule

bind sec_fix_top sec_fix_chk #(.CNT_W(CNT_W)) i_sec_fix_chk (
  .clk_i, .rst_ni, .start_i, .busy_o, .done_o, .fail_o, .erased_o, .fixed_o
);

// File: tb/test_sec_fix_top.sv
module test_sec_fix_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ld_valid = 1'b0, ld_par = 1'b0;
  logic [8:0]  ld_addr = '0, rd_addr = '0;
  logic [7:0]  ld_data = '0, rd_data;
  logic        start = 1'b0, uncor = 1'b0;
  logic [2:0]  err_cnt = '0, rec_idx, fixed;
  logic [31:0] rec;
  logic        busy, done, fail, erased;
  logic [31:0] recs [8];
  logic [7:0]  ref_mem [512];
  int          checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rec = recs[rec_idx];

  sec_fix_top i_sec_fix_top (
    .clk_i(clk), .rst_ni(rst_n), .ld_valid_i(ld_valid), .ld_par_i(ld_par),
    .ld_addr_i(ld_addr), .ld_data_i(ld_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .start_i(start), .err_cnt_i(err_cnt), .uncor_i(uncor), .rec_idx_o(rec_idx),
    .rec_i(rec), .busy_o(busy), .done_o(done), .fail_o(fail), .erased_o(erased),
    .fixed_o(fixed)
  );

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] mk_rec(int loc, int mask);
    logic [8:0] l = 9'(loc);
    logic [8:0] m = 9'(mask);
    return {7'b1010011, l, 7'b0110101, m};
  endfunction

  // model: returns 1 when the record is applied
  function automatic int model_apply(logic [31:0] r);
    int loc = int'(r[24:16]);
    int i, b;
    logic [15:0] sh;
    if (loc == 0) return 0;
    i = loc - 1;
    b = i + (i >> 3);
    if (b >= 512) return 0;
    sh = 16'(r[8:0]) << (i % 8);
    ref_mem[b] ^= sh[7:0];
    if (b + 1 < 512) ref_mem[b+1] ^= sh[15:8];
    return 1;
  endfunction

  task automatic load(bit par, int addr, logic [7:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_par = par; ld_addr = 9'(addr); ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic run(int cnt, bit unc);
    @(negedge clk);
    start = 1'b1; err_cnt = 3'(cnt); uncor = unc;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic readback(string req);
    for (int a = 0; a < 512; a++) begin
      @(negedge clk);
      rd_addr = 9'(a);
      @(negedge clk);
      chk(req, int'(rd_data), int'(ref_mem[a]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int exp_fix;
    for (int k = 0; k < 8; k++) recs[k] = '0;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk("R8 reset busy", int'(busy), 0);
    chk("R8 reset done", int'(done), 0);
    rst_n = 1'b1;

    // R10 load a patterned sector, parity not erased
    for (int a = 0; a < 512; a++) begin
      ref_mem[a] = 8'((a * 37 + 11) & 8'hFF);
      load(1'b0, a, ref_mem[a]);
    end
    for (int p = 0; p < 9; p++) load(1'b1, 0, 8'(8'h12 + p));

    // R1 R2 R3 R4 R5: sweep every location, seven per run
    for (int g = 0; g < 74; g++) begin
      int n = (g == 73) ? 1 : 7;
      exp_fix = 0;
      for (int j = 0; j < n; j++) begin
        recs[j] = mk_rec(g * 7 + j, ((g * 7 + j) * 29 + 3) | 1);
        exp_fix += model_apply(recs[j]);
      end
      run(n, 1'b0);
      chk("R3 R4 fixed count", int'(fixed), exp_fix);
      chk("R6 fail clear", int'(fail), 0);
      chk("R7 not erased", int'(erased), 0);
      @(negedge clk);
      chk("R8 done pulse", int'(done), 0);
    end
    readback("R2 sweep data");

    // R5 count zero
    recs[0] = mk_rec(5, 9'h1FF);
    run(0, 1'b0);
    chk("R5 zero count", int'(fixed), 0);

    // R5 only the first count records are used
    recs[0] = mk_rec(20, 9'h0F0); recs[1] = mk_rec(21, 9'h00F); recs[2] = mk_rec(22, 9'h1FF);
    exp_fix = model_apply(recs[0]) + model_apply(recs[1]);
    run(2, 1'b0);
    chk("R5 partial count", int'(fixed), exp_fix);

    // R2 repeated record cancels itself
    recs[0] = mk_rec(100, 9'h155); recs[1] = mk_rec(100, 9'h155);
    run(2, 1'b0);
    chk("R2 duplicate count", int'(fixed), 2);

    // R6 uncorrectable
    recs[0] = mk_rec(3, 9'h1FF); recs[1] = mk_rec(4, 9'h1FF);
    run(2, 1'b1);
    chk("R6 fail set", int'(fail), 1);
    chk("R6 no fixes", int'(fixed), 0);

    // R9 load and start during a run are ignored
    recs[0] = mk_rec(40, 9'h033); recs[1] = mk_rec(41, 9'h0C0);
    exp_fix = model_apply(recs[0]) + model_apply(recs[1]);
    @(negedge clk);
    start = 1'b1; err_cnt = 3'd2; uncor = 1'b0;
    @(negedge clk);
    start = 1'b1; ld_valid = 1'b1; ld_par = 1'b0; ld_addr = 9'd3; ld_data = 8'hAA;
    @(negedge clk);
    start = 1'b0; ld_valid = 1'b0;
    while (!done) @(negedge clk);
    chk("R9 fixed", int'(fixed), exp_fix);
    repeat (3) @(negedge clk);
    chk("R9 no restart", int'(busy), 0);
    readback("R9 R6 R5 data");

    // R7 erased sector bypasses even with uncorrectable set
    for (int a = 0; a < 512; a++) begin
      ref_mem[a] = 8'hFF;
      load(1'b0, a, 8'hFF);
    end
    for (int p = 0; p < 9; p++) load(1'b1, 0, 8'hFF);
    recs[0] = mk_rec(1, 9'h1FF); recs[1] = mk_rec(300, 9'h0AA);
    run(2, 1'b1);
    chk("R7 erased flag", int'(erased), 1);
    chk("R7 fail clear", int'(fail), 0);
    chk("R7 no fixes", int'(fixed), 0);
    readback("R7 erased data");

    // R7 one parity byte off: correction proceeds
    for (int a = 0; a < 512; a++) load(1'b0, a, 8'hFF);
    for (int p = 0; p < 9; p++) load(1'b1, 0, (p == 4) ? 8'hFE : 8'hFF);
    recs[0] = mk_rec(1, 9'h1FF);
    exp_fix = model_apply(recs[0]);
    run(1, 1'b0);
    chk("R7 near erased flag", int'(erased), 0);
    chk("R7 near erased fixed", int'(fixed), exp_fix);
    @(negedge clk); rd_addr = 9'd0;
    @(negedge clk); chk("R2 byte0", int'(rd_data), 8'h00);
    @(negedge clk); rd_addr = 9'd1;
    @(negedge clk); chk("R2 byte1", int'(rd_data), 8'hFE);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule